// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory. It watches an open-drain clock line and data line. It pulls the data line low to acknowledge a byte or to put a zero read bit on the bus. A transaction starts with a control byte. That byte carries a fixed device-type code, three select bits that are compared against strap inputs, and a read/write flag. A write sequence then brings a two-byte word address, followed by zero or more data bytes. A read sequence returns bytes from a 4096 x 8 array, starting at the internal address pointer.

Written bytes collect in a 32-byte page buffer. They reach the array only when a STOP arrives on a byte boundary. The STOP also opens a self-timed programming window of a parameterised number of system clocks, and during that window the block acknowledges nothing. A bus master can therefore poll with control bytes until one is acknowledged. Both bus lines pass through a two-flop synchroniser, and all bus events are detected in the system clock domain. The system clock must be much faster than the bus clock.

Top module: `eeprom2w_slave`

## Requirements
- R1: After reset the data line is released (`sda_drive_low` = 0) and the block waits for a START.
- R2: A control byte is acknowledged only when its upper four bits are 1010 and its next three bits equal `strap_sel`. Its last bit set to 1 selects a read and set to 0 selects a write. Any other control byte gets no acknowledge.
- R3: An acknowledge holds SDA low through the ninth SCL pulse and starts only while SCL is low. It is released once SCL falls again.
- R4: A write sends the word address as two bytes: the high byte first, each byte most significant bit first. Address bits 11:8 sit in the low nibble of the high byte, and that byte's upper nibble must be zero or the byte is not acknowledged.
- R5: Data bytes are stored only when a STOP follows a complete, acknowledged byte (at most one bit of the next byte clocked). A STOP in the middle of a byte discards the whole write and starts no programming window.
- R6: Successive data bytes in one write go to successive addresses that wrap inside the 32-byte page (address bits 11:5 stay fixed).
- R7: For PROG_CYCLES system clocks after a committing STOP, no control byte is acknowledged. After that window a control byte is acknowledged again.
- R8: A random read is done with a write of the word address, a repeated START and a control byte with the read bit set. It returns the byte stored at that address.
- R9: A read with no address phase (current-address read) returns the byte one past the last byte read.
- R10: While the master acknowledges, a read keeps returning bytes from incrementing addresses, and address 0xFFF is followed by 0x000.
- R11: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R12: A START while SCL is high (SDA falling) is recognised at any point, even inside a byte, and restarts control-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| strap_sel | input | 3 | Select-bit straps compared with the control byte |
| sda_drive_low | output | 1 | 1 pulls the data line low (open-drain enable) |

## Verification
Errors in the bit counter or the byte-phase state show up at the ports within one bus byte. An error of this kind either misses the ninth-clock acknowledge or moves it, or it shifts read bits by one position, so the damage is visible within about nine SCL periods. An error in the address pointer or the page-wrap logic does not disturb the bus timing. It surfaces only when bytes are read back, so the bench reads back every address it writes, and it crosses the page and array boundaries on purpose. An error in the programming timer shows up in how many polls go unacknowledged, and in whether a STOP in the middle of a byte wrongly opens a busy window.

// File: rtl/eeprom2w_pkg.sv
package eeprom2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_AHI, ST_ALO, ST_WDAT, ST_RD, ST_RACK
  } st_t;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eeprom2w_sync.sv
module eeprom2w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_lvl;
      sda_d  <= sda_lvl;
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/eeprom2w_pagebuf.sv
module eeprom2w_pagebuf #(
  parameter int PAGE_W = 5,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [DW-1:0]     wdata,
  input  logic              clr,
  input  logic [PAGE_W-1:0] ridx,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              any_valid
);
  localparam int SLOTS = 1 << PAGE_W;
  logic [DW-1:0]    slot [SLOTS];
  logic [SLOTS-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we) vld[widx] <= 1'b1;
  end

  assign rdata     = slot[ridx];
  assign rvalid    = vld[ridx];
  assign any_valid = |vld;
endmodule

// File: rtl/eeprom2w_ram.sv
module eeprom2w_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_sel,
  output logic       sda_drive_low
);
  import eeprom2w_pkg::*;

  localparam int HI_W       = ADDR_W - 8;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(PROG_CYCLES);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  st_t  st, st_after;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, ram_q, pb_rdata;
  logic in_ack, mack, busy;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0] ahi;
  logic [ADDR_W-PAGE_W-1:0] prog_page;
  logic [CNT_W-1:0] pcnt;
  logic byte_done, ctrl_ok, ahi_ok, pb_we, pb_clr, pb_valid, pb_any;
  logic prog_last, commit, ram_we;

  eeprom2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev));

  assign byte_done = scl_fall && !in_ack && (bit_cnt == 4'd8) && !start_ev && !stop_ev;
  assign ctrl_ok   = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3:1] == strap_sel) && !busy;
  assign ahi_ok    = ((rx_sh >> HI_W) == 8'd0);
  assign prog_last = busy && (pcnt == CNT_W'(PROG_CYCLES - 1));
  assign pb_we     = (st == ST_WDAT) && byte_done;
  assign pb_clr    = ((st == ST_AHI) && byte_done && ahi_ok) || prog_last;
  assign commit    = stop_ev && (st == ST_WDAT) && !in_ack && (bit_cnt <= 4'd1) && pb_any;
  assign ram_we    = busy && (pcnt < CNT_W'(PAGE_BYTES)) && pb_valid;

  eeprom2w_pagebuf #(.PAGE_W(PAGE_W), .DW(8)) u_pbuf (
    .clk(clk), .rst(rst), .we(pb_we), .widx(ptr[PAGE_W-1:0]), .wdata(rx_sh),
    .clr(pb_clr), .ridx(pcnt[PAGE_W-1:0]), .rdata(pb_rdata),
    .rvalid(pb_valid), .any_valid(pb_any));

  eeprom2w_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr({prog_page, pcnt[PAGE_W-1:0]}),
    .wdata(pb_rdata), .raddr(ptr), .rdata(ram_q));

  // programming window timer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pcnt      <= '0;
      prog_page <= '0;
    end else if (commit) begin
      busy      <= 1'b1;
      pcnt      <= '0;
      prog_page <= ptr[ADDR_W-1:PAGE_W];
    end else if (prog_last) begin
      busy <= 1'b0;
      pcnt <= '0;
    end else if (busy) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // bus protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; st_after <= ST_IDLE;
      bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0;
      in_ack <= 1'b0; mack <= 1'b1; sda_drive_low <= 1'b0;
      ptr <= '0; ahi <= '0;
    end else if (start_ev) begin
      st <= ST_CTRL; bit_cnt <= '0; in_ack <= 1'b0; sda_drive_low <= 1'b0;
    end else if (stop_ev) begin
      st <= ST_IDLE; in_ack <= 1'b0; sda_drive_low <= 1'b0;
    end else begin
      case (st)
        ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && in_ack) begin
            in_ack  <= 1'b0;
            bit_cnt <= '0;
            st      <= st_after;
            if (st_after == ST_RD) begin
              tx_sh <= ram_q; sda_drive_low <= ~ram_q[7];
              bit_cnt <= 4'd1; ptr <= ptr + 1'b1;
            end else begin
              sda_drive_low <= 1'b0;
            end
          end else if (byte_done) begin
            if (st == ST_CTRL) begin
              if (ctrl_ok) begin
                in_ack <= 1'b1; sda_drive_low <= 1'b1;
                st_after <= rx_sh[0] ? ST_RD : ST_AHI;
              end else st <= ST_IDLE;
            end else if (st == ST_AHI) begin
              if (ahi_ok) begin
                ahi <= rx_sh[HI_W-1:0];
                in_ack <= 1'b1; sda_drive_low <= 1'b1; st_after <= ST_ALO;
              end else st <= ST_IDLE;
            end else if (st == ST_ALO) begin
              ptr <= {ahi, rx_sh};
              in_ack <= 1'b1; sda_drive_low <= 1'b1; st_after <= ST_WDAT;
            end else begin
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
              in_ack <= 1'b1; sda_drive_low <= 1'b1; st_after <= ST_WDAT;
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_drive_low <= 1'b0; st <= ST_RACK;
            end else begin
              sda_drive_low <= ~tx_sh[6];
              tx_sh   <= {tx_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= sda_lvl;
          else if (scl_fall) begin
            if (!mack) begin
              tx_sh <= ram_q; sda_drive_low <= ~ram_q[7];
              bit_cnt <= 4'd1; ptr <= ptr + 1'b1; st <= ST_RD;
            end else st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom2w_chk.sv
module eeprom2w_chk #(
  parameter int PROG_CYCLES = 1500,
  parameter int CNT_W       = 11,
  parameter int PG_W        = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                scl_lvl,
  input logic                sda_drive_low,
  input logic                busy,
  input logic                in_ack,
  input eeprom2w_pkg::st_t   st,
  input logic [CNT_W-1:0]    pcnt,
  input logic [PG_W-1:0]     ptr_page
);
  import eeprom2w_pkg::*;

  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !sda_drive_low); // R1
  AST_DRIVE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !scl_lvl); // R3
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ack); // R7
  AST_PROG_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(pcnt) < PROG_CYCLES)); // R7
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WDAT && $past(st) == ST_WDAT) |-> $stable(ptr_page)); // R6
  AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RACK) |-> !sda_drive_low); // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_drive_low); // R11
endmodule

bind eeprom2w_slave eeprom2w_chk #(
  .PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W), .PG_W(ADDR_W - PAGE_W)
) u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_drive_low(sda_drive_low),
  .busy(busy), .in_ack(in_ack), .st(st), .pcnt(pcnt),
  .ptr_page(ptr[ADDR_W-1:PAGE_W])
);

// File: tb/sim_eeprom2w_slave.sv
`timescale 1ns/1ps
module sim_eeprom2w_slave;
  localparam int HALF = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [19:0] VEC [6] = '{
    {12'h000, 8'h5A}, {12'hFFF, 8'hC3}, {12'h123, 8'h81},
    {12'h124, 8'h00}, {12'h800, 8'hA5}, {12'h7FF, 8'h3C}
  };

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_drive_low;
  wire  sda_bus = sda_m & ~sda_drive_low;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  eeprom2w_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_sel(STRAP), .sda_drive_low(sda_drive_low));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic half(); wclk(HALF); endtask

  function automatic logic [7:0] ctl(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic b_start();
    sda_m = 1'b1; half(); scl_m = 1'b1; half(); sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask
  task automatic b_stop();
    sda_m = 1'b0; half(); scl_m = 1'b1; half(); sda_m = 1'b1; half();
  endtask
  task automatic b_bit(input logic v);
    sda_m = v; half(); scl_m = 1'b1; half(); scl_m = 1'b0;
  endtask
  task automatic b_send(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) b_bit(b[i]);
    sda_m = 1'b1; half(); scl_m = 1'b1; half(); acked = ~sda_bus; scl_m = 1'b0;
  endtask
  task automatic b_recv(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl_m = 1'b1; half(); b[i] = sda_bus; scl_m = 1'b0;
    end
    sda_m = nack; half(); scl_m = 1'b1; half(); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic wr_seq(input logic [11:0] a, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input int n, output logic ok);
    logic ak;
    ok = 1'b1;
    b_start();
    b_send(ctl(1'b0), ak); ok &= ak;
    b_send({4'h0, a[11:8]}, ak); ok &= ak;
    b_send(a[7:0], ak); ok &= ak;
    b_send(d0, ak); ok &= ak;
    if (n > 1) begin b_send(d1, ak); ok &= ak; end
    if (n > 2) begin b_send(d2, ak); ok &= ak; end
    b_stop();
  endtask

  task automatic wait_ready(output int polls);
    logic ak;
    polls = 0;
    for (int p = 0; p < 30; p++) begin
      b_start(); b_send(ctl(1'b0), ak); b_stop();
      if (ak) break;
      polls++;
    end
  endtask

  task automatic rd_random(input logic [11:0] a, input logic nack, output logic [7:0] d,
                           output logic ok);
    logic ak;
    ok = 1'b1;
    b_start();
    b_send(ctl(1'b0), ak); ok &= ak;
    b_send({4'h0, a[11:8]}, ak); ok &= ak;
    b_send(a[7:0], ak); ok &= ak;
    b_start();
    b_send(ctl(1'b1), ak); ok &= ak;
    b_recv(nack, d);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ok, ak;
    logic [7:0] d, d2;
    int polls, lows;
    wclk(5);
    chk("R1 drive during reset", sda_drive_low, 0);
    rst = 1'b0;
    wclk(5);
    chk("R1 drive after reset", sda_drive_low, 0);

    // vector table: byte write, poll, random read back
    for (int k = 0; k < 6; k++) begin
      wr_seq(VEC[k][19:8], VEC[k][7:0], 8'h00, 8'h00, 1, ok);
      chk("R5 write acks", ok, 1);
      wait_ready(polls);
      rd_random(VEC[k][19:8], 1'b1, d, ok);
      b_stop();
      chk("R8 R4 random read acks", ok, 1);
      chk("R5 R8 R4 read back", d, VEC[k][7:0]);
    end

    // R2: select and type code mismatch
    b_start(); b_send({4'b1010, 3'b011, 1'b0}, ak); b_stop();
    chk("R2 wrong strap nack", ak, 0);
    b_start(); b_send({4'b1011, STRAP, 1'b0}, ak); b_stop();
    chk("R2 wrong type nack", ak, 0);

    // R3: ack released after ninth falling edge
    b_start(); b_send(ctl(1'b0), ak);
    chk("R3 ack on ninth clock", ak, 1);
    wclk(8);
    chk("R3 ack released", sda_drive_low, 0);
    // R4: upper nibble of high address byte nonzero
    b_send(8'h10, ak); b_stop();
    chk("R4 high nibble nack", ak, 0);

    // R7: busy window
    wr_seq(12'h200, 8'h77, 8'h00, 8'h00, 1, ok);
    b_start(); b_send(ctl(1'b0), ak); b_stop();
    chk("R7 nack while busy", ak, 0);
    wait_ready(polls);
    chk("R7 ready after window", (polls > 0 && polls < 30), 1);
    rd_random(12'h200, 1'b1, d, ok); b_stop();
    chk("R7 committed data", d, 8'h77);

    // R5: STOP inside a byte discards the write
    b_start(); b_send(ctl(1'b0), ak); b_send(8'h02, ak); b_send(8'h00, ak);
    for (int i = 0; i < 4; i++) b_bit(1'b0);
    b_stop();
    b_start(); b_send(ctl(1'b0), ak); b_stop();
    chk("R5 no busy after mid-byte stop", ak, 1);
    rd_random(12'h200, 1'b1, d, ok); b_stop();
    chk("R5 data unchanged", d, 8'h77);

    // R6: page wrap
    wr_seq(12'h03E, 8'h11, 8'h22, 8'h33, 3, ok);
    wait_ready(polls);
    rd_random(12'h03E, 1'b1, d, ok); b_stop();
    chk("R6 page byte 0x03E", d, 8'h11);
    rd_random(12'h03F, 1'b1, d, ok); b_stop();
    chk("R6 page byte 0x03F", d, 8'h22);
    rd_random(12'h020, 1'b1, d, ok); b_stop();
    chk("R6 wrapped byte 0x020", d, 8'h33);

    // R9: current-address read
    rd_random(12'h123, 1'b1, d, ok); b_stop();
    b_start(); b_send(ctl(1'b1), ak); b_recv(1'b1, d); b_stop();
    chk("R9 current address read", d, 8'h00);

    // R10: sequential rollover
    rd_random(12'hFFF, 1'b0, d, ok);
    b_recv(1'b1, d2); b_stop();
    chk("R10 seq byte 0xFFF", d, 8'hC3);
    chk("R10 seq rollover 0x000", d2, 8'h5A);

    // R11: master nack ends read (next byte 0x124 is 0x00)
    rd_random(12'h123, 1'b1, d, ok);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      half(); scl_m = 1'b1; half();
      if (sda_drive_low) lows++;
      scl_m = 1'b0;
    end
    b_stop();
    chk("R11 byte before nack", d, 8'h81);
    chk("R11 no drive after nack", lows, 0);

    // R12: START inside a byte restarts
    b_start();
    for (int i = 0; i < 3; i++) b_bit(1'b1);
    b_start(); b_send(ctl(1'b0), ak); b_stop();
    chk("R12 restart mid-byte", ak, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule